// File: doc/BRIEF.md
# Scan-Port Memory Bridge

This block is a complete test access port controller, clocked by the test clock, whose instruction set is widened with private opcodes. These opcodes turn the serial scan chain into a simple byte bus into an internal register space. A host loads an 8-bit address through one data register. It then reads the byte at that address through a second data register, or writes a byte through a third. Each memory access is an ordinary Capture-DR / Shift-DR / Update-DR pass.

Other private opcodes do their work when the instruction is loaded rather than through a data register. Two of them emit one-cycle pulses: a software reboot request and a fault-log save request. Four of them set or clear a sticky page select that chooses between the default, extended and nonvolatile address spaces. The page select stays in force until a matching clear opcode runs or the port passes through Test-Logic-Reset.

The serial output changes on the falling test clock edge. Its enable is low in every state other than Shift-DR and Shift-IR.

Top module: `tapMemBridge`

## Requirements
- R1: After `trstN` goes low, the instruction is IDCODE, so a 32-bit DR scan returns the `ID_CODE` parameter (default 32'h1B4D3057), LSB first, and `pageSel` is 2'b00.
- R2: A 5-bit IR scan shifts out the binary value 00001 (LSB first, so the first bit out is 1), whatever instruction was loaded before.
- R3: Opcode 5'h1F selects the 1-bit bypass register, which captures 0. Every opcode with no assigned meaning also selects bypass, so a 4-bit scan of `b` returns `{b[2:0],1'b0}`.
- R4: Opcode 5'h02 selects the 8-bit address register. Capture-DR loads the current address, and Update-DR drives the shifted value onto `memAddr`.
- R5: Opcode 5'h04 selects the 8-bit write register. Update-DR latches the shifted byte onto `memWdata` and raises `memWe` for exactly one test clock cycle, with `memAddr` unchanged.
- R6: Opcode 5'h03 selects the 8-bit read register. In Capture-DR, `memRe` is high for one cycle and `memRdata` is loaded, so the scan returns the byte at `memAddr`.
- R7: Loading opcode 5'h05 gives one `rebootPulse` cycle that begins at the Update-IR clock edge. `savePulse` stays low during it.
- R8: Loading opcode 5'h06 gives one `savePulse` cycle that begins at the Update-IR clock edge. `rebootPulse` stays low during it.
- R9: Opcode 5'h07 sets `pageSel` to 2'b01 (extended), and opcode 5'h08 returns it to 2'b00 (default). Both are sticky across later instructions.
- R10: Opcode 5'h09 sets `pageSel` to 2'b10 (nonvolatile), and opcode 5'h0A returns it to 2'b00.
- R11: Five TMS-high clocks reach Test-Logic-Reset. This clears `pageSel` to 2'b00 and restores IDCODE, without using `trstN`.
- R12: `tdoOe` is high only while the port is in Shift-DR or Shift-IR. `tdo` and `tdoOe` change on the falling edge of `tck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdoOe | output | 1 | Output enable for `tdo` (high in shift states) |
| memAddr | output | 8 | Address for register space access |
| memWdata | output | 8 | Write data |
| memWe | output | 1 | One-cycle write strobe |
| memRe | output | 1 | Read strobe, high during read capture |
| memRdata | input | 8 | Read data, valid in the cycle `memRe` is high |
| pageSel | output | 2 | 00 default, 01 extended, 10 nonvolatile |
| rebootPulse | output | 1 | One-cycle software reboot request |
| savePulse | output | 1 | One-cycle fault-log save request |

## Verification
The assertions check several properties on every cycle. The write strobe and both request pulses last exactly one cycle. The two pulses never overlap. Test-Logic-Reset always leaves the page select at default and the instruction at IDCODE. The output enable is only ever high in a shift state. What only the bench scenarios can show is the serial data path: the instruction capture pattern, the bypass delay, and bytes written and read back at several addresses. They also show that page modes are sticky across unrelated instructions and that unknown opcodes fall back to bypass.

// File: rtl/tapMemPkg.sv
`timescale 1ns/1ps
package tapMemPkg;
  localparam int IR_W = 5;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 5'h01;
  localparam logic [IR_W-1:0] OP_ADDR    = 5'h02;
  localparam logic [IR_W-1:0] OP_READ    = 5'h03;
  localparam logic [IR_W-1:0] OP_WRITE   = 5'h04;
  localparam logic [IR_W-1:0] OP_REBOOT  = 5'h05;
  localparam logic [IR_W-1:0] OP_SAVE    = 5'h06;
  localparam logic [IR_W-1:0] OP_EXT_ON  = 5'h07;
  localparam logic [IR_W-1:0] OP_EXT_OFF = 5'h08;
  localparam logic [IR_W-1:0] OP_NV_ON   = 5'h09;
  localparam logic [IR_W-1:0] OP_NV_OFF  = 5'h0A;
  localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;

  localparam logic [1:0] PAGE_DEF = 2'b00;
  localparam logic [1:0] PAGE_EXT = 2'b01;
  localparam logic [1:0] PAGE_NV  = 2'b10;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapStateT;

  typedef enum logic [2:0] {
    SEL_BYPASS, SEL_IDCODE, SEL_ADDR, SEL_READ, SEL_WRITE
  } drSelT;

  typedef struct packed {
    logic  tlr;
    logic  captureDr;
    logic  shiftDr;
    logic  updateDr;
    logic  shiftIr;
    drSelT drSel;
    logic  doReboot;
    logic  doSave;
    logic  doExtOn;
    logic  doExtOff;
    logic  doNvOn;
    logic  doNvOff;
  } tapStrobesT;
endpackage

// File: rtl/tapMemCtrl.sv
`timescale 1ns/1ps
module tapMemCtrl
  import tapMemPkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  output tapStrobesT strobes,
  output logic       irTdo
);
  tapStateT state, stateNext;
  logic [IR_W-1:0] irShift, irReg;

  always_comb begin
    unique case (state)
      ST_TLR:    stateNext = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    stateNext = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: stateNext = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: stateNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  stateNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: stateNext = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: stateNext = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: stateNext = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: stateNext = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: stateNext = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: stateNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  stateNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: stateNext = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: stateNext = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: stateNext = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: stateNext = tms ? ST_SEL_DR : ST_RTI;
      default:   stateNext = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_TLR;
    else        state <= stateNext;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irReg   <= OP_IDCODE;
    end else begin
      if (state == ST_CAP_IR)     irShift <= IR_CAPTURE;
      else if (state == ST_SH_IR) irShift <= {tdi, irShift[IR_W-1:1]};
      if (state == ST_TLR)        irReg <= OP_IDCODE;
      else if (state == ST_UPD_IR) irReg <= irShift;
    end
  end

  logic inUpdIr;
  assign inUpdIr = (state == ST_UPD_IR);

  always_comb begin
    strobes = '0;
    strobes.tlr       = (state == ST_TLR);
    strobes.captureDr = (state == ST_CAP_DR);
    strobes.shiftDr   = (state == ST_SH_DR);
    strobes.updateDr  = (state == ST_UPD_DR);
    strobes.shiftIr   = (state == ST_SH_IR);
    unique case (irReg)
      OP_IDCODE: strobes.drSel = SEL_IDCODE;
      OP_ADDR:   strobes.drSel = SEL_ADDR;
      OP_READ:   strobes.drSel = SEL_READ;
      OP_WRITE:  strobes.drSel = SEL_WRITE;
      default:   strobes.drSel = SEL_BYPASS;
    endcase
    strobes.doReboot = inUpdIr && (irShift == OP_REBOOT);
    strobes.doSave   = inUpdIr && (irShift == OP_SAVE);
    strobes.doExtOn  = inUpdIr && (irShift == OP_EXT_ON);
    strobes.doExtOff = inUpdIr && (irShift == OP_EXT_OFF);
    strobes.doNvOn   = inUpdIr && (irShift == OP_NV_ON);
    strobes.doNvOff  = inUpdIr && (irShift == OP_NV_OFF);
  end

  assign irTdo = irShift[0];

  // R11: leaving Test-Logic-Reset always leaves IDCODE selected
  assert_tlr_idcode_R11: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_TLR) |=> (strobes.drSel == SEL_IDCODE));
  // R2: the shift register holds the capture pattern on entering Shift-IR
  assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_CAP_IR) |=> (irShift == IR_CAPTURE));
endmodule

// File: rtl/tapMemData.sv
`timescale 1ns/1ps
module tapMemData
  import tapMemPkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8,
  parameter logic [31:0] ID_CODE = 32'h1B4D3057
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tdi,
  input  tapStrobesT        strobes,
  input  logic              irTdo,
  output logic              tdo,
  output logic              tdoOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [1:0]        pageSel,
  output logic              rebootPulse,
  output logic              savePulse
);
  localparam int ID_W = 32;

  logic              bypassBit;
  logic [ID_W-1:0]   idShift;
  logic [ADDR_W-1:0] addrShift, addrReg;
  logic [DATA_W-1:0] dataShift, wdataReg;
  logic              weQ, drTdo, serialOut;
  logic [1:0]        pageQ;

  assign memRe = strobes.captureDr && (strobes.drSel == SEL_READ);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
      idShift   <= ID_CODE;
      addrShift <= '0;
      dataShift <= '0;
      addrReg   <= '0;
      wdataReg  <= '0;
      weQ       <= 1'b0;
    end else begin
      weQ <= 1'b0;
      if (strobes.captureDr) begin
        bypassBit <= 1'b0;
        idShift   <= ID_CODE;
        addrShift <= addrReg;
        dataShift <= (strobes.drSel == SEL_READ) ? memRdata : wdataReg;
      end else if (strobes.shiftDr) begin
        unique case (strobes.drSel)
          SEL_IDCODE: idShift   <= {tdi, idShift[ID_W-1:1]};
          SEL_ADDR:   addrShift <= {tdi, addrShift[ADDR_W-1:1]};
          SEL_READ,
          SEL_WRITE:  dataShift <= {tdi, dataShift[DATA_W-1:1]};
          default:    bypassBit <= tdi;
        endcase
      end else if (strobes.updateDr) begin
        if (strobes.drSel == SEL_ADDR) addrReg <= addrShift;
        if (strobes.drSel == SEL_WRITE) begin
          wdataReg <= dataShift;
          weQ      <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      pageQ       <= PAGE_DEF;
      rebootPulse <= 1'b0;
      savePulse   <= 1'b0;
    end else begin
      rebootPulse <= strobes.doReboot;
      savePulse   <= strobes.doSave;
      if (strobes.tlr)                             pageQ <= PAGE_DEF;
      else if (strobes.doExtOn)                    pageQ <= PAGE_EXT;
      else if (strobes.doNvOn)                     pageQ <= PAGE_NV;
      else if (strobes.doExtOff || strobes.doNvOff) pageQ <= PAGE_DEF;
    end
  end

  always_comb begin
    unique case (strobes.drSel)
      SEL_IDCODE: drTdo = idShift[0];
      SEL_ADDR:   drTdo = addrShift[0];
      SEL_READ,
      SEL_WRITE:  drTdo = dataShift[0];
      default:    drTdo = bypassBit;
    endcase
    serialOut = strobes.shiftIr ? irTdo : drTdo;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdo   <= serialOut;
      tdoOe <= strobes.shiftIr || strobes.shiftDr;
    end
  end

  assign memAddr  = addrReg;
  assign memWdata = wdataReg;
  assign memWe    = weQ;
  assign pageSel  = pageQ;

  // R5: write strobe is a single cycle and the address holds around it
  assert_we_single_R5: assert property (@(posedge tck) disable iff (!trstN)
    memWe |=> (!memWe && $stable(memAddr)));
  // R7: reboot request lasts one cycle
  assert_reboot_single_R7: assert property (@(posedge tck) disable iff (!trstN)
    rebootPulse |=> !rebootPulse);
  // R8: save request lasts one cycle and never overlaps reboot
  assert_save_single_R8: assert property (@(posedge tck) disable iff (!trstN)
    savePulse |=> !savePulse);
  assert_pulse_exclusive_R8: assert property (@(posedge tck) disable iff (!trstN)
    !(savePulse && rebootPulse));
  // R11: Test-Logic-Reset forces the default page
  assert_tlr_page_R11: assert property (@(posedge tck) disable iff (!trstN)
    strobes.tlr |=> (pageSel == PAGE_DEF));
  // R12: output enable only in a shift state
  assert_oe_shift_R12: assert property (@(posedge tck) disable iff (!trstN)
    tdoOe |-> (strobes.shiftDr || strobes.shiftIr));
endmodule

// File: rtl/tapMemBridge.sv
`timescale 1ns/1ps
module tapMemBridge
  import tapMemPkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8,
  parameter logic [31:0] ID_CODE = 32'h1B4D3057
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdoOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [1:0]        pageSel,
  output logic              rebootPulse,
  output logic              savePulse
);
  tapStrobesT strobes;
  logic       irTdo;

  tapMemCtrl i_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .strobes(strobes), .irTdo(irTdo)
  );

  tapMemData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_CODE(ID_CODE)) i_data (
    .tck(tck), .trstN(trstN), .tdi(tdi), .strobes(strobes), .irTdo(irTdo),
    .tdo(tdo), .tdoOe(tdoOe), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .memRdata(memRdata), .pageSel(pageSel),
    .rebootPulse(rebootPulse), .savePulse(savePulse)
  );
endmodule

// File: tb/test_tapMemBridge.sv
`timescale 1ns/1ps
module test_tapMemBridge;
  logic       tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic       tdo, tdoOe, memWe, memRe, rebootPulse, savePulse;
  logic [7:0] memAddr, memWdata, memRdata;
  logic [1:0] pageSel;
  logic [7:0] mem [256];
  int checks = 0, errors = 0, reCount = 0;

  localparam logic [31:0] EXP_ID = 32'h1B4D3057;
  localparam int NVEC = 6;
  // {address, data}
  localparam logic [15:0] VEC [NVEC] = '{16'h00A5, 16'hFF3C, 16'h1001, 16'h7F80, 16'h55AA, 16'h10F0};

  always #10 tck = ~tck;

  tapMemBridge i_tapMemBridge (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoOe(tdoOe),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .pageSel(pageSel), .rebootPulse(rebootPulse), .savePulse(savePulse)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
  always @(posedge tck) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) reCount <= reCount + 1;
  end
  assign memRdata = mem[memAddr];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic tmsV, input logic tdiV, output logic tdoV, output logic oeV);
    @(negedge tck); #2;
    tdoV = tdo; oeV = tdoOe;
    tms = tmsV; tdi = tdiV;
    @(posedge tck); #4;
  endtask

  task automatic step(input logic tmsV);
    logic a, b;
    tick(tmsV, 1'b0, a, b);
  endtask

  task automatic scanIr(input logic [4:0] op, output logic [4:0] out, output logic oeSeen);
    logic o, oe;
    step(1); step(1); step(0); step(0);
    oeSeen = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick(i == 4, op[i], o, oe);
      out[i] = o;
      oeSeen &= oe;
    end
    step(1); step(0);
  endtask

  task automatic loadIr(input logic [4:0] op);
    logic [4:0] d; logic e;
    scanIr(op, d, e);
  endtask

  task automatic scanDr(input logic [31:0] din, input int n, output logic [31:0] dout);
    logic o, oe;
    dout = '0;
    step(1); step(0); step(0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o, oe);
      dout[i] = o;
    end
    step(1); step(0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [4:0]  irOut;
    logic        oe, o;
    int          reBefore;

    repeat (3) @(posedge tck);
    #4 trstN = 1'b1;
    step(0);
    // R1: reset state
    check(pageSel == 2'b00, "R1 page after reset", 32'(pageSel), 0);
    check(tdoOe == 1'b0, "R12 oe idle", 32'(tdoOe), 0);
    scanDr(32'h0, 32, d);
    check(d == EXP_ID, "R1 idcode", d, EXP_ID);

    // R2: capture pattern, first bits out
    scanIr(5'h1F, irOut, oe);
    check(irOut == 5'b00001, "R2 ir capture", 32'(irOut), 1);
    check(oe == 1'b1, "R12 oe during Shift-IR", 32'(oe), 1);
    // R3: bypass
    scanDr(32'hB, 4, d);
    check(d[3:0] == 4'b0110, "R3 bypass 1F", 32'(d[3:0]), 32'h6);
    tick(0, 0, o, oe);
    check(oe == 1'b0, "R12 oe after shift", 32'(oe), 0);
    loadIr(5'h15);
    scanDr(32'h5, 4, d);
    check(d[3:0] == 4'b1010, "R3 bypass unknown opcode", 32'(d[3:0]), 32'hA);

    // Vector table: R4 load address, R5 write, R6 read back
    for (int v = 0; v < NVEC; v++) begin
      loadIr(5'h02);
      scanDr({24'h0, VEC[v][15:8]}, 8, d);
      check(memAddr == VEC[v][15:8], "R4 address update", 32'(memAddr), 32'(VEC[v][15:8]));
      loadIr(5'h04);
      scanDr({24'h0, VEC[v][7:0]}, 8, d);
      check(memWe && memWdata == VEC[v][7:0] && memAddr == VEC[v][15:8], "R5 write strobe",
            {15'h0, memWe, memAddr, memWdata}, {15'h0, 1'b1, VEC[v]});
      step(0);
      check(memWe == 1'b0, "R5 strobe one cycle", 32'(memWe), 0);
      loadIr(5'h03);
      reBefore = reCount;
      scanDr(32'h0, 8, d);
      check(d[7:0] == VEC[v][7:0], "R6 read back", 32'(d[7:0]), 32'(VEC[v][7:0]));
      check(reCount == reBefore + 1, "R6 one read strobe", reCount, reBefore + 1);
    end

    // R6: untouched location
    loadIr(5'h02); scanDr(32'h33, 8, d);
    loadIr(5'h03); scanDr(32'h0, 8, d);
    check(d[7:0] == (8'h33 ^ 8'h5A), "R6 preset byte", 32'(d[7:0]), 32'(8'h33 ^ 8'h5A));
    // R4: capture returns current address
    loadIr(5'h02); scanDr(32'h0, 8, d);
    check(d[7:0] == 8'h33, "R4 address capture", 32'(d[7:0]), 32'h33);

    // R7 reboot
    loadIr(5'h05);
    check(rebootPulse && !savePulse, "R7 reboot pulse", {rebootPulse, savePulse}, 2'b10);
    step(0);
    check(!rebootPulse, "R7 reboot one cycle", 32'(rebootPulse), 0);
    // R8 save
    loadIr(5'h06);
    check(savePulse && !rebootPulse, "R8 save pulse", {rebootPulse, savePulse}, 2'b01);
    step(0);
    check(!savePulse, "R8 save one cycle", 32'(savePulse), 0);

    // R9 extended page, sticky
    loadIr(5'h07);
    check(pageSel == 2'b01, "R9 ext on", 32'(pageSel), 1);
    loadIr(5'h03); scanDr(32'h0, 8, d);
    check(pageSel == 2'b01, "R9 ext sticky", 32'(pageSel), 1);
    loadIr(5'h08);
    check(pageSel == 2'b00, "R9 ext off", 32'(pageSel), 0);
    // R10 nonvolatile page
    loadIr(5'h09);
    check(pageSel == 2'b10, "R10 nv on", 32'(pageSel), 2);
    loadIr(5'h1F);
    check(pageSel == 2'b10, "R10 nv sticky", 32'(pageSel), 2);
    loadIr(5'h0A);
    check(pageSel == 2'b00, "R10 nv off", 32'(pageSel), 0);

    // R11 TMS reset
    loadIr(5'h07);
    loadIr(5'h1F);
    for (int i = 0; i < 5; i++) step(1);
    step(0);
    check(pageSel == 2'b00, "R11 page cleared", 32'(pageSel), 0);
    scanDr(32'h0, 32, d);
    check(d == EXP_ID, "R11 idcode restored", d, EXP_ID);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule